// File: doc/BRIEF.md
# Serial Potentiometer Command Decoder

This block is the serial front end of a digitally controlled potentiometer. It acts as a mode-0 slave on a four-wire serial link and adds a pause input. It samples the data input on rising serial-clock edges and changes the data output on falling edges. Each frame opens with an identification byte, which must carry a fixed device type and two address bits matching the strap pins. An instruction byte follows, holding a four-bit opcode, a two-bit register index and a two-bit bank index.

The block turns each accepted command into one-cycle strobes on a parallel request interface. The strobes carry the selected register and, for writes, the data byte. Reads ask the host logic for a byte and shift it out serially. An increment/decrement command turns every further serial-clock pulse into a step request, with its direction taken from the data input. Register storage, the wiper counter and nonvolatile write timing live outside the block.

All serial inputs are synchronised to the system clock, which must run at least eight times faster than the serial clock. Edges are detected in the system-clock domain.

Top module: `serpot_cmd`

## Requirements
- R1: The first byte of a frame is taken MSB first and must equal `0101 00 A1 A0`, where A1 A0 match `dev_addr_i[1:0]`. Any other value, including a nonzero value in the two reserved bits, makes the block ignore the rest of the frame.
- R2: A frame starts only on a falling edge of `cs_ni` and is abandoned when `cs_ni` goes high. If `cs_ni` is already low when reset is released, no command is accepted until `cs_ni` has risen and fallen again.
- R3: Opcode 1010 (write wiper) and opcode 1100 (write data register) take a third byte. One strobe (`wr_wiper_o` or `wr_reg_o`) is issued after the 24th bit, with that byte on `wr_data_o`. A frame that ends before the 24th bit issues no strobe.
- R4: Opcode 1101 pulses `xfer_to_wiper_o` after the 16th bit, and opcode 1110 pulses `xfer_from_wiper_o` after the 16th bit. Bits clocked after that are ignored.
- R5: The instruction byte is `op[3:0] RB RA P1 P0`, and `reg_sel_o = {P1,P0,RB,RA}`. Wiper writes and reads, both transfers and increment/decrement are ignored unless P1 = P0 = 0. Data-register reads and writes accept any bank.
- R6: Opcode 1001 (read wiper, `rd_src_o`=0) and opcode 1011 (read data register, `rd_src_o`=1) pulse `rd_req_o` after the 16th bit. `rd_data_i` is captured in the cycle of that pulse. The byte then appears on `so_o` MSB first, one bit per falling serial-clock edge, so the host samples D7 at rising edge 17 and D0 at rising edge 24.
- R7: Opcode 0001 (read status, `rd_src_o`=2) returns seven zero bits followed by `wip_i` as the last bit.
- R8: Opcode 0010 starts a stream of unbounded length. Every later rising serial-clock edge pulses `step_o`, and `step_up_o` equals the data input sampled at that edge (1 = toward the high end). The stream lasts until `cs_ni` rises.
- R9: While the pause input `hold_ni` is low, serial-clock edges are ignored and `so_oe_o` is low. The frame position is kept. A pause starts or ends only while the serial clock is low.
- R10: `so_oe_o` is high only during the read data phase of a selected, unpaused frame. It is low after reset and whenever `cs_ni` is high.
- R11: Any opcode other than the eight listed is ignored for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Chip select, active low |
| hold_ni | input | 1 | Pause, active low |
| dev_addr_i | input | 2 | Strapped device address A1 A0 |
| wip_i | input | 1 | Write-in-progress flag from storage |
| rd_data_i | input | 8 | Read byte from host logic for the current request |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data out (tri-state control) |
| reg_sel_o | output | 4 | {bank[1:0], register[1:0]} of the current command |
| wr_data_o | output | 8 | Write data byte |
| wr_wiper_o | output | 1 | Write-wiper strobe |
| wr_reg_o | output | 1 | Write-data-register strobe |
| xfer_to_wiper_o | output | 1 | Data register to wiper strobe |
| xfer_from_wiper_o | output | 1 | Wiper to data register strobe |
| step_o | output | 1 | Increment/decrement step strobe |
| step_up_o | output | 1 | Step direction, 1 = up |
| rd_req_o | output | 1 | Read request strobe |
| rd_src_o | output | 2 | Read source: 0 wiper, 1 data register, 2 status |

## Verification
A pause request and a serial-clock rising edge can arrive in the same system cycle. The bench provokes this by lowering `hold_ni` at the very moment it raises the serial clock for a data bit of a wiper write. That bit must still count, because a pause is only taken once the clock is low. The garbage pulses clocked during the pause must then be dropped, so the frame must yield exactly one write strobe with the intended byte. A paused read frame is also checked: `so_oe_o` must fall during the pause, and the byte read afterwards must be intact.

// File: rtl/serpot_pkg.sv
package serpot_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [5:0] ID_PREFIX = 6'b0101_00;

  localparam logic [3:0] OP_RD_WIPER  = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER  = 4'b1010;
  localparam logic [3:0] OP_RD_REG    = 4'b1011;
  localparam logic [3:0] OP_WR_REG    = 4'b1100;
  localparam logic [3:0] OP_REG2WIPER = 4'b1101;
  localparam logic [3:0] OP_WIPER2REG = 4'b1110;
  localparam logic [3:0] OP_STEP      = 4'b0010;
  localparam logic [3:0] OP_STATUS    = 4'b0001;

  localparam logic [1:0] RSRC_WIPER  = 2'd0;
  localparam logic [1:0] RSRC_REG    = 2'd1;
  localparam logic [1:0] RSRC_STATUS = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_CMD, ST_WDATA, ST_RDATA, ST_STEP, ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/serpot_sync.sv
module serpot_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[s] <= RST_VAL;
        else         st[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[s] <= RST_VAL;
        else         st[s] <= st[s-1];
      end
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/serpot_frame.sv
module serpot_frame
  import serpot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              si_i,
  input  logic              cs_high_i,
  input  logic              cs_fall_i,
  input  logic [1:0]        dev_addr_i,
  output logic [3:0]        reg_sel_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_wiper_o,
  output logic              wr_reg_o,
  output logic              xfer_to_wiper_o,
  output logic              xfer_from_wiper_o,
  output logic              step_o,
  output logic              step_up_o,
  output logic              rd_req_o,
  output logic [1:0]        rd_src_o,
  output logic              rd_phase_o
);
  frame_st_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] sh;
  logic              wdata_wiper;
  logic [BYTE_W-1:0] byte_v;
  logic              byte_done;
  logic              bank0;

  assign byte_v    = {sh, si_i};
  assign byte_done = rise_i && (cnt == CNT_W'(BYTE_W - 1));
  assign bank0     = (byte_v[1:0] == 2'b00);
  assign rd_phase_o = (state == ST_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state             <= ST_IDLE;
      cnt               <= '0;
      sh                <= '0;
      wdata_wiper       <= 1'b0;
      reg_sel_o         <= '0;
      wr_data_o         <= '0;
      wr_wiper_o        <= 1'b0;
      wr_reg_o          <= 1'b0;
      xfer_to_wiper_o   <= 1'b0;
      xfer_from_wiper_o <= 1'b0;
      step_o            <= 1'b0;
      step_up_o         <= 1'b0;
      rd_req_o          <= 1'b0;
      rd_src_o          <= RSRC_WIPER;
    end else begin
      wr_wiper_o        <= 1'b0;
      wr_reg_o          <= 1'b0;
      xfer_to_wiper_o   <= 1'b0;
      xfer_from_wiper_o <= 1'b0;
      step_o            <= 1'b0;
      rd_req_o          <= 1'b0;
      if (cs_high_i) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (cs_fall_i) begin
        state <= ST_ID;
        cnt   <= '0;
      end else if (rise_i && state != ST_IDLE) begin
        sh  <= byte_v[BYTE_W-2:0];
        cnt <= cnt + 1'b1;
        unique case (state)
          ST_ID: if (byte_done)
            state <= (byte_v[7:2] == ID_PREFIX && byte_v[1:0] == dev_addr_i)
                     ? ST_CMD : ST_SKIP;
          ST_CMD: if (byte_done) begin
            reg_sel_o <= {byte_v[1:0], byte_v[3:2]};
            state     <= ST_SKIP;
            unique case (byte_v[7:4])
              OP_RD_WIPER: if (bank0) begin
                rd_req_o <= 1'b1; rd_src_o <= RSRC_WIPER; state <= ST_RDATA;
              end
              OP_RD_REG: begin
                rd_req_o <= 1'b1; rd_src_o <= RSRC_REG; state <= ST_RDATA;
              end
              OP_STATUS: begin
                rd_req_o <= 1'b1; rd_src_o <= RSRC_STATUS; state <= ST_RDATA;
              end
              OP_WR_WIPER: if (bank0) begin
                wdata_wiper <= 1'b1; state <= ST_WDATA;
              end
              OP_WR_REG: begin
                wdata_wiper <= 1'b0; state <= ST_WDATA;
              end
              OP_REG2WIPER: if (bank0) xfer_to_wiper_o <= 1'b1;
              OP_WIPER2REG: if (bank0) xfer_from_wiper_o <= 1'b1;
              OP_STEP: if (bank0) state <= ST_STEP;
              default: state <= ST_SKIP;
            endcase
          end
          ST_WDATA: if (byte_done) begin
            wr_data_o  <= byte_v;
            wr_wiper_o <= wdata_wiper;
            wr_reg_o   <= !wdata_wiper;
            state      <= ST_SKIP;
          end
          ST_RDATA: if (byte_done) state <= ST_SKIP;
          ST_STEP: begin
            step_o    <= 1'b1;
            step_up_o <= si_i;
          end
          default: ;
        endcase
      end
    end
  end

  // data strobes only follow a serial rising edge
  p_wr_after_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_wiper_o || wr_reg_o) |-> $past(rise_i));

  p_wiper_bank0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_wiper_o || xfer_to_wiper_o || xfer_from_wiper_o || step_o) |-> (reg_sel_o[3:2] == 2'b00));

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_wiper_o, wr_reg_o, xfer_to_wiper_o, xfer_from_wiper_o, step_o, rd_req_o}));
endmodule

// File: rtl/serpot_shift_out.sv
module serpot_shift_out
  import serpot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  input  logic              fall_i,
  input  logic              en_i,
  output logic              so_o
);
  logic [BYTE_W-1:0] sh;
  logic              so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh   <= '0;
      so_q <= 1'b0;
    end else if (load_i) begin
      sh <= load_val_i;
    end else if (fall_i && en_i) begin
      so_q <= sh[BYTE_W-1];
      sh   <= {sh[BYTE_W-2:0], 1'b0};
    end
  end

  assign so_o = so_q;

  p_so_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(so_q) |-> $past(fall_i && en_i));
endmodule

// File: rtl/serpot_cmd.sv
module serpot_cmd
  import serpot_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        si_i,
  input  logic        cs_ni,
  input  logic        hold_ni,
  input  logic [1:0]  dev_addr_i,
  input  logic        wip_i,
  input  logic [7:0]  rd_data_i,
  output logic        so_o,
  output logic        so_oe_o,
  output logic [3:0]  reg_sel_o,
  output logic [7:0]  wr_data_o,
  output logic        wr_wiper_o,
  output logic        wr_reg_o,
  output logic        xfer_to_wiper_o,
  output logic        xfer_from_wiper_o,
  output logic        step_o,
  output logic        step_up_o,
  output logic        rd_req_o,
  output logic [1:0]  rd_src_o
);
  localparam int SYNC_STAGES = 2;

  logic [3:0] sync_q;
  logic sck_d, si_d, cs_d, hold_d;
  logic sck_q, cs_q, paused;
  logic rise, fall, rd_phase;
  logic [BYTE_W-1:0] load_val;

  // cs resets low so a select held low through reset is not seen as a fall
  serpot_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hold_ni, cs_ni, si_i, sck_i}),
    .q_o   (sync_q)
  );
  assign {hold_d, cs_d, si_d, sck_d} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b0;
      paused <= 1'b0;
    end else begin
      sck_q <= sck_d;
      cs_q  <= cs_d;
      if (cs_d)        paused <= 1'b0;
      else if (!sck_d) paused <= !hold_d;
    end
  end

  assign rise = sck_d && !sck_q && !paused;
  assign fall = !sck_d && sck_q && !paused;

  serpot_frame u_frame (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .rise_i           (rise),
    .si_i             (si_d),
    .cs_high_i        (cs_d),
    .cs_fall_i        (cs_q && !cs_d),
    .dev_addr_i       (dev_addr_i),
    .reg_sel_o        (reg_sel_o),
    .wr_data_o        (wr_data_o),
    .wr_wiper_o       (wr_wiper_o),
    .wr_reg_o         (wr_reg_o),
    .xfer_to_wiper_o  (xfer_to_wiper_o),
    .xfer_from_wiper_o(xfer_from_wiper_o),
    .step_o           (step_o),
    .step_up_o        (step_up_o),
    .rd_req_o         (rd_req_o),
    .rd_src_o         (rd_src_o),
    .rd_phase_o       (rd_phase)
  );

  assign load_val = (rd_src_o == RSRC_STATUS) ? {{(BYTE_W-1){1'b0}}, wip_i} : rd_data_i;

  serpot_shift_out u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (rd_req_o),
    .load_val_i(load_val),
    .fall_i    (fall),
    .en_i      (rd_phase),
    .so_o      (so_o)
  );

  assign so_oe_o = rd_phase && !paused;

  p_pause_sck_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused) |-> $past(!sck_d));

  p_so_hiz_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_d |=> !so_oe_o);

  p_cs_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_d |=> !(wr_wiper_o || wr_reg_o || xfer_to_wiper_o || xfer_from_wiper_o || step_o || rd_req_o));
endmodule

// File: tb/serpot_cmd_bench.sv
module serpot_cmd_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1, wip = 1'b1;
  logic [1:0] dev_addr = 2'b10;
  logic [7:0] rd_data;
  logic so, so_oe, wr_wiper, wr_reg, x2w, w2x, step, step_up, rd_req;
  logic [3:0] reg_sel;
  logic [7:0] wr_data;
  logic [1:0] rd_src;

  int total = 0, bad = 0;
  int n_evt = 0, last_evt = 0, n_up = 0, n_dn = 0;
  logic [3:0] last_sel = '0;
  logic [7:0] last_data = '0;

  always #5 clk = ~clk;

  assign rd_data = (rd_src == 2'd0) ? 8'h5A : {4'hC, reg_sel};

  serpot_cmd u_serpot_cmd (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .si_i(si), .cs_ni(cs_n), .hold_ni(hold_n),
    .dev_addr_i(dev_addr), .wip_i(wip), .rd_data_i(rd_data), .so_o(so), .so_oe_o(so_oe),
    .reg_sel_o(reg_sel), .wr_data_o(wr_data), .wr_wiper_o(wr_wiper), .wr_reg_o(wr_reg),
    .xfer_to_wiper_o(x2w), .xfer_from_wiper_o(w2x), .step_o(step), .step_up_o(step_up),
    .rd_req_o(rd_req), .rd_src_o(rd_src)
  );

  always @(posedge clk) begin
    if (wr_wiper) begin n_evt++; last_evt = 1; last_data = wr_data; last_sel = reg_sel; end
    if (wr_reg)   begin n_evt++; last_evt = 2; last_data = wr_data; last_sel = reg_sel; end
    if (x2w)      begin n_evt++; last_evt = 3; last_sel = reg_sel; end
    if (w2x)      begin n_evt++; last_evt = 4; last_sel = reg_sel; end
    if (step)     begin n_evt++; last_evt = 5; if (step_up) n_up++; else n_dn++; end
    if (rd_req)   begin n_evt++; last_evt = 6; last_sel = reg_sel; end
  end

  typedef struct packed {
    logic [7:0] idb;
    logic [7:0] cmd;
    logic [7:0] dat;
    logic [4:0] nb;
    logic [2:0] evt;
    logic [1:0] cnt;
    logic       chk_rd;
    logic [7:0] rdv;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h52, 8'hA0, 8'h3C, 5'd24, 3'd1, 2'd1, 1'b0, 8'h00},
    '{8'h52, 8'hC7, 8'h81, 5'd24, 3'd2, 2'd1, 1'b0, 8'h00},
    '{8'h52, 8'hD8, 8'h00, 5'd16, 3'd3, 2'd1, 1'b0, 8'h00},
    '{8'h52, 8'hE4, 8'h00, 5'd16, 3'd4, 2'd1, 1'b0, 8'h00},
    '{8'h52, 8'hA1, 8'h3C, 5'd24, 3'd0, 2'd0, 1'b0, 8'h00},
    '{8'h53, 8'hA0, 8'h3C, 5'd24, 3'd0, 2'd0, 1'b0, 8'h00},
    '{8'h56, 8'hA0, 8'h3C, 5'd24, 3'd0, 2'd0, 1'b0, 8'h00},
    '{8'h52, 8'h90, 8'h00, 5'd24, 3'd6, 2'd1, 1'b1, 8'h5A},
    '{8'h52, 8'hBE, 8'h00, 5'd24, 3'd6, 2'd1, 1'b1, 8'hCB},
    '{8'h52, 8'h10, 8'h00, 5'd24, 3'd6, 2'd1, 1'b1, 8'h01},
    '{8'h52, 8'hF0, 8'h3C, 5'd24, 3'd0, 2'd0, 1'b0, 8'h00},
    '{8'h52, 8'hA0, 8'h3C, 5'd20, 3'd0, 2'd0, 1'b0, 8'h00},
    '{8'h52, 8'hD1, 8'h00, 5'd16, 3'd0, 2'd0, 1'b0, 8'h00}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1: return "R3";
      2, 3: return "R4";
      4, 12: return "R5";
      5, 6: return "R1";
      7, 8: return "R6";
      9: return "R7";
      10: return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic smp);
    si = b;
    wait_clk(HALF);
    smp = so;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [23:0] bits, input int n, output logic [7:0] rd);
    logic smp;
    rd = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      clk_bit(bits[23-i], smp);
      if (i >= 16 && i < 24) rd = {rd[6:0], smp};
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic clr();
    n_evt = 0; last_evt = 0; n_up = 0; n_dn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic smp;
    // cs low through reset
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R10 reset oe", so_oe, 0);
    chk("R2 reset strobes", n_evt, 0);

    // R2: no frame without a select falling edge after reset
    for (int i = 0; i < 24; i++) clk_bit(1'({8'h52, 8'hA0, 8'h3C} >> (23 - i)), smp);
    wait_clk(HALF);
    chk("R2 no fall no cmd", n_evt, 0);
    cs_n = 1'b1;
    wait_clk(2 * HALF);

    for (int v = 0; v < NV; v++) begin
      clr();
      frame({VECS[v].idb, VECS[v].cmd, VECS[v].dat}, int'(VECS[v].nb), rd);
      chk({vtag(v), " count"}, n_evt, int'(VECS[v].cnt));
      if (VECS[v].cnt == 2'd1) begin
        chk({vtag(v), " kind"}, last_evt, int'(VECS[v].evt));
        chk({vtag(v), " sel"}, last_sel, {VECS[v].cmd[1:0], VECS[v].cmd[3:2]});
        if (VECS[v].evt == 3'd1 || VECS[v].evt == 3'd2)
          chk({vtag(v), " data"}, last_data, VECS[v].dat);
      end
      if (VECS[v].chk_rd) chk({vtag(v), " read"}, rd, VECS[v].rdv);
      chk("R10 oe after cs high", so_oe, 0);
    end

    // R8: unbounded step stream
    clr();
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 16; i++) clk_bit(1'({8'h52, 8'h20} >> (15 - i)), smp);
    for (int i = 0; i < 30; i++) clk_bit(1'(i % 3 != 0), smp);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    chk("R8 steps", n_evt, 30);
    chk("R8 up", n_up, 20);
    chk("R8 down", n_dn, 10);

    // R9: pause in the middle of a data register write
    clr();
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 10; i++) clk_bit(1'({8'h52, 8'hC7, 8'h81} >> (23 - i)), smp);
    hold_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, smp);
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 10; i < 24; i++) clk_bit(1'({8'h52, 8'hC7, 8'h81} >> (23 - i)), smp);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    chk("R9 pause count", n_evt, 1);
    chk("R9 pause data", last_data, 8'h81);

    // R9: pause request in the same cycle as a rising serial edge
    clr();
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 17; i++) clk_bit(1'({8'h52, 8'hA0, 8'h96} >> (23 - i)), smp);
    si = 1'b0;
    wait_clk(HALF);
    sck = 1'b1; hold_n = 1'b0;
    wait_clk(HALF);
    sck = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, smp);
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 18; i < 24; i++) clk_bit(1'({8'h52, 8'hA0, 8'h96} >> (23 - i)), smp);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    chk("R9 same-cycle count", n_evt, 1);
    chk("R9 same-cycle data", last_data, 8'h96);

    // R9/R10: pause during a read phase
    clr();
    rd = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 18; i++) begin
      clk_bit(1'({8'h52, 8'h90} >> (15 - (i < 16 ? i : 15))) & (i < 16), smp);
      if (i >= 16) rd = {rd[6:0], smp};
    end
    chk("R10 oe in read", so_oe, 1);
    hold_n = 1'b0;
    wait_clk(HALF);
    chk("R9 oe paused", so_oe, 0);
    for (int i = 0; i < 2; i++) clk_bit(1'b0, smp);
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 18; i < 24; i++) begin
      clk_bit(1'b0, smp);
      rd = {rd[6:0], smp};
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    chk("R9 read after pause", rd, 8'h5A);
    chk("R6 read count", n_evt, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule